// File: doc/BRIEF.md
# Sampling ADC Conversion and Serial Host Controller

This block drives an external sampling converter from the host side of a chip. For each accepted request it launches a conversion, follows the converter's busy line, and runs one 16-bit full-duplex serial frame. During that frame a control word is shifted out on the converter's data input while the conversion result is shifted in from its data output. The frame is enclosed by an active-low sync. The serial clock is divided down from the system clock. All converter timing rules are met with system-clock counters set by parameters: the start pulse width, the acquisition spacing, and the serial clock half period.

Three sequences are available. In pin-start mode the block pulses the start pin and then runs the frame either after busy falls or while busy is still high (overlapped). In software-start mode the start pin is never pulsed. The frame itself carries the command that starts the conversion, and the block then waits out the resulting busy period. Requests are taken through a ready/valid port. A request offered while a sequence is still running is not accepted. Each frame ends with a one-cycle result strobe and the received word.

All converter inputs are assumed to be synchronous to `clk_i`.

Top module: `adc_host_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `req_ready_o` is 1, `adc_sync_no` is 1, `adc_sclk_o` is 0, `adc_convst_o` is 0 and `res_valid_o` is 0.
- R2: In pin-start mode each request raises `adc_convst_o` exactly once, for exactly CONVST_CYC consecutive system clock cycles.
- R3: A rising edge of `adc_convst_o` (pin mode), or the start of a frame in software mode, comes at least ACQ_CYC system clock cycles after the last falling edge of `adc_busy_i`, and never while `adc_busy_i` is high.
- R4: A frame holds `adc_sync_no` low for 16 rising edges of `adc_sclk_o`. Each serial clock phase lasts SCLK_HALF system clock cycles, and the clock idles low. The control word is sent on `adc_din_o` with bit 15 first.
- R5: `adc_din_o` changes only at the sync falling edge or at falling serial clock edges, so it is stable across every rising edge.
- R6: With `req_overlap_i`=0 and `req_sw_start_i`=0, the frame starts only after `adc_busy_i` has risen and then fallen again.
- R7: With `req_overlap_i`=1 and `req_sw_start_i`=0, the frame starts while `adc_busy_i` is high. `req_ready_o` returns only after `adc_busy_i` is low again.
- R8: With `req_sw_start_i`=1 (which overrides `req_overlap_i`), `adc_convst_o` stays low. The frame runs first, and then the block waits for `adc_busy_i` to rise and fall before it is ready again.
- R9: `res_valid_o` is high for exactly one cycle per frame. `res_word_o` then holds the 16 bits taken from `adc_dout_i` on the rising serial clock edges, with the first bit in bit 15.
- R10: `req_ready_o` is low from acceptance until the sequence completes. A `req_valid_i` presented while it is low starts no conversion and no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_word_i | input | 16 | Control word for the frame |
| req_overlap_i | input | 1 | Pin mode: 1 runs the frame during conversion, 0 after it |
| req_sw_start_i | input | 1 | 1 selects a software-started conversion (no start pulse) |
| res_valid_o | output | 1 | One-cycle strobe at frame end |
| res_word_o | output | 16 | Word received in the last frame |
| adc_convst_o | output | 1 | Conversion start pulse to the converter |
| adc_busy_i | input | 1 | Converter busy line |
| adc_sync_no | output | 1 | Active-low frame sync |
| adc_sclk_o | output | 1 | Serial clock |
| adc_din_o | output | 1 | Serial data to the converter |
| adc_dout_i | input | 1 | Serial data from the converter |

## Verification
The bench runs two overlapped requests back to back, so the second start pulse has to wait for the acquisition window. A controller that does not count that window pulses the start pin only a few cycles after busy falls, and the measured spacing catches it. It also checks on which side of busy each frame starts: a block that mixes up the after and overlapped modes starts the frame with busy at the wrong level. In software-start runs, any pulse on the start pin, or a return to ready before the triggered conversion ends, is flagged. Requests offered while the controller is busy must produce no second frame and no second result strobe, even over a long quiet period afterwards. Every frame is checked for phase lengths, the number of rising edges, the bit order both ways, and data stability across rising edges.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACQ,
    S_PULSE,
    S_WAIT_HI,
    S_WAIT_LO,
    S_FRAME
  } seq_state_e;
endpackage

// File: rtl/adc_acq_timer.sv
module adc_acq_timer #(
  parameter int unsigned ACQ_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic acq_ok_o
);
  localparam int unsigned AW = $clog2(ACQ_CYC + 1);
  localparam logic [AW-1:0] ACQ_MAX = AW'(ACQ_CYC);

  logic          busy_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= ACQ_MAX;
    end else begin
      busy_q <= busy_i;
      if (busy_q && !busy_i)   cnt_q <= '0;
      else if (cnt_q != ACQ_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign acq_ok_o = (cnt_q == ACQ_MAX) && !busy_i;

  p_acq_after_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !busy_i) |=> !acq_ok_o);
endmodule

// File: rtl/adc_pulse_gen.sv
module adc_pulse_gen #(
  parameter int unsigned PULSE_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int unsigned PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

  logic          on_q;
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!on_q) begin
      if (fire_i) begin
        on_q  <= 1'b1;
        cnt_q <= '0;
      end
    end else if (cnt_q == LAST) begin
      on_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = on_q;
  assign done_o  = on_q && (cnt_q == LAST);

  p_no_refire_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !pulse_o);
endmodule

// File: rtl/adc_frame_eng.sv
module adc_frame_eng #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SCLK_HALF = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_i,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_o,
  output logic              sync_no,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int unsigned HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int unsigned BW = $clog2(WORD_W);
  localparam logic [HW-1:0] H_LAST = HW'(SCLK_HALF - 1);
  localparam logic [BW-1:0] B_LAST = BW'(WORD_W - 1);

  logic              active_q, sclk_q, done_q;
  logic [HW-1:0]     hc_q;
  logic [BW-1:0]     bc_q;
  logic [WORD_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      hc_q     <= '0;
      bc_q     <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          tx_q     <= tx_i;
          hc_q     <= '0;
          bc_q     <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (hc_q == H_LAST) begin
        hc_q   <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          rx_q <= {rx_q[WORD_W-2:0], sdi_i};
        end else if (bc_q == B_LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          bc_q <= bc_q + 1'b1;
          tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end

  assign sync_no = !active_q;
  assign sclk_o  = sclk_q;
  assign sdo_o   = tx_q[WORD_W-1];
  assign rx_o    = rx_q;
  assign done_o  = done_q;

  p_sclk_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_no |-> !sclk_o);
  p_din_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdo_o));
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int unsigned CONVST_CYC = 5,
  parameter int unsigned ACQ_CYC    = 20,
  parameter int unsigned SCLK_HALF  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [WORD_W-1:0] req_word_i,
  input  logic              req_overlap_i,
  input  logic              req_sw_start_i,
  output logic              res_valid_o,
  output logic [WORD_W-1:0] res_word_o,
  output logic              adc_convst_o,
  input  logic              adc_busy_i,
  output logic              adc_sync_no,
  output logic              adc_sclk_o,
  output logic              adc_din_o,
  input  logic              adc_dout_i
);
  seq_state_e        st_q, st_d;
  logic [WORD_W-1:0] word_q;
  logic              ovl_q, sw_q;
  logic              acq_ok, pulse_done, frm_done;
  logic              fire, frm_start;

  adc_acq_timer #(.ACQ_CYC(ACQ_CYC)) i_acq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (adc_busy_i),
    .acq_ok_o(acq_ok)
  );

  adc_pulse_gen #(.PULSE_CYC(CONVST_CYC)) i_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .pulse_o(adc_convst_o),
    .done_o (pulse_done)
  );

  adc_frame_eng #(.WORD_W(WORD_W), .SCLK_HALF(SCLK_HALF)) i_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(frm_start),
    .tx_i   (word_q),
    .done_o (frm_done),
    .rx_o   (res_word_o),
    .sync_no(adc_sync_no),
    .sclk_o (adc_sclk_o),
    .sdo_o  (adc_din_o),
    .sdi_i  (adc_dout_i)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (req_valid_i) st_d = S_ACQ;
      S_ACQ:     if (acq_ok) st_d = sw_q ? S_FRAME : S_PULSE;
      S_PULSE:   if (pulse_done) st_d = S_WAIT_HI;
      S_WAIT_HI: if (adc_busy_i) st_d = (ovl_q && !sw_q) ? S_FRAME : S_WAIT_LO;
      S_WAIT_LO: if (!adc_busy_i) st_d = (sw_q || ovl_q) ? S_IDLE : S_FRAME;
      S_FRAME:   if (frm_done) st_d = sw_q ? S_WAIT_HI : (ovl_q ? S_WAIT_LO : S_IDLE);
      default:   st_d = S_IDLE;
    endcase
  end

  assign fire        = (st_q != S_PULSE) && (st_d == S_PULSE);
  assign frm_start   = (st_q != S_FRAME) && (st_d == S_FRAME);
  assign req_ready_o = (st_q == S_IDLE);
  assign res_valid_o = frm_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      word_q <= '0;
      ovl_q  <= 1'b0;
      sw_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && req_valid_i) begin
        word_q <= req_word_i;
        ovl_q  <= req_overlap_i;
        sw_q   <= req_sw_start_i;
      end
    end
  end

  p_convst_idle_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_convst_o) |-> !adc_busy_i);
  p_after_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adc_sync_no) && !ovl_q && !sw_q) |-> !adc_busy_i);
  p_ovl_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adc_sync_no) && ovl_q && !sw_q) |-> adc_busy_i);
  p_sw_no_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q && st_q != S_IDLE) |-> !adc_convst_o);
  p_ready_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (adc_sync_no && !adc_convst_o));
endmodule

// File: tb/test_adc_host_ctrl.sv
module test_adc_host_ctrl;
  localparam int CLK_PERIOD = 20;
  localparam int CONVST_CYC = 5;
  localparam int ACQ_CYC    = 20;
  localparam int SCLK_HALF  = 7;
  localparam int CONV_LEN   = 300;
  localparam int TMO        = 4000;

  // {overlap, sw_start, control word, converter result}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b0, 16'hC350, 16'h0ABC},
    {1'b1, 1'b0, 16'h8002, 16'h5A5A},
    {1'b1, 1'b0, 16'hFFFE, 16'h0000},
    {1'b0, 1'b1, 16'h4A01, 16'hF00F},
    {1'b0, 1'b0, 16'h7FFE, 16'h8001},
    {1'b1, 1'b1, 16'h0001, 16'hFFFF}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_ovl = 1'b0, req_sw = 1'b0;
  logic [15:0] req_word = '0;
  logic req_ready, res_valid, convst, sync_n, sclk, din;
  logic [15:0] res_word;
  logic busy = 1'b0, dout = 1'b0;

  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_host_ctrl #(.CONVST_CYC(CONVST_CYC), .ACQ_CYC(ACQ_CYC), .SCLK_HALF(SCLK_HALF)) i_adc_host_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_word_i(req_word),
    .req_overlap_i(req_ovl), .req_sw_start_i(req_sw),
    .res_valid_o(res_valid), .res_word_o(res_word),
    .adc_convst_o(convst), .adc_busy_i(busy), .adc_sync_no(sync_n),
    .adc_sclk_o(sclk), .adc_din_o(din), .adc_dout_i(dout)
  );

  // converter model
  logic [15:0] adc_tx = '0, m_sh = '0, m_rx = '0, m_last = '0;
  int m_rises = 0, m_last_rises = 0, frames = 0, din_bad = 0;
  int sw_req_cnt = 0, sw_ack_cnt = 0, conv_starts = 0, conv_left = 0;
  time din_t = 0;
  logic convst_q = 1'b0;

  always @(din) din_t = $time;
  always @(negedge sync_n) begin
    m_sh = adc_tx; dout = m_sh[15]; m_rx = '0; m_rises = 0;
  end
  always @(posedge sclk) if (!sync_n) begin
    m_rx = {m_rx[14:0], din}; m_rises++;
    if ($time - din_t < CLK_PERIOD) din_bad++;
  end
  always @(negedge sclk) if (!sync_n) begin
    m_sh = {m_sh[14:0], 1'b0}; dout = m_sh[15];
  end
  always @(posedge sync_n) begin
    m_last = m_rx; m_last_rises = m_rises; frames++;
    if (m_rx[0]) sw_req_cnt++;
  end
  always @(posedge clk) begin
    convst_q <= convst;
    if ((convst && !convst_q) || (sw_req_cnt != sw_ack_cnt)) begin
      sw_ack_cnt <= sw_req_cnt;
      busy <= 1'b1; conv_left <= CONV_LEN; conv_starts <= conv_starts + 1;
    end else if (busy) begin
      if (conv_left == 1) busy <= 1'b0;
      conv_left <= conv_left - 1;
    end
  end

  // monitors, sampled mid-cycle
  int cyc = 0, fall_cyc = -100000, gap = 100000, pulse_run = 0, pulse_w = 0, convst_rises = 0;
  int half_run = 0, half_bad = 0, valid_cnt = 0;
  logic busy_p = 1'b0, convst_p = 1'b0, sync_p = 1'b1, sclk_p = 1'b0, sync_busy = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (busy_p && !busy) fall_cyc = cyc;
    if (convst && !convst_p) begin gap = cyc - fall_cyc; convst_rises++; pulse_run = 1; end
    else if (convst) pulse_run++;
    if (!convst && convst_p) pulse_w = pulse_run;
    if (sync_p && !sync_n) begin sync_busy = busy; half_run = 1; end
    else if (!sync_n) begin
      if (sclk != sclk_p) begin if (half_run != SCLK_HALF) half_bad++; half_run = 1; end
      else half_run++;
    end
    if (res_valid) valid_cnt++;
    busy_p = busy; convst_p = convst; sync_p = sync_n; sclk_p = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!req_ready && n < TMO) begin @(negedge clk); n++; end
    chk(req_ready, "R10 ready timeout", 0, 1);
  endtask

  task automatic run_req(input logic ovl, input logic sw, input logic [15:0] w, input logic [15:0] rw);
    int n, p0, c0, f0, v0;
    wait_ready();
    adc_tx = rw; half_bad = 0; din_bad = 0;
    p0 = convst_rises; c0 = conv_starts; f0 = frames;
    req_valid = 1'b1; req_ovl = ovl; req_sw = sw; req_word = w;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < TMO) begin @(negedge clk); n++; end
    chk(res_valid == 1'b1, "R9 result strobe", int'(res_valid), 1);
    chk(res_word == rw, "R9 result word", int'(res_word), int'(rw));
    @(negedge clk);
    chk(res_valid == 1'b0, "R9 strobe one cycle", int'(res_valid), 0);
    wait_ready();
    chk(m_last == w, "R4 control word msb first", int'(m_last), int'(w));
    chk(m_last_rises == 16 && half_bad == 0, "R4 frame clocks", m_last_rises, 16);
    chk(din_bad == 0, "R5 din stable at rising edge", din_bad, 0);
    chk(frames == f0 + 1, "R10 one frame per request", frames - f0, 1);
    if (sw) begin
      chk(convst_rises == p0, "R8 no start pulse", convst_rises - p0, 0);
      chk(conv_starts == c0 + 1 && !busy, "R8 waited out conversion", conv_starts - c0, 1);
    end else begin
      chk(convst_rises == p0 + 1 && pulse_w == CONVST_CYC, "R2 start pulse width", pulse_w, CONVST_CYC);
      chk(gap >= ACQ_CYC, "R3 acquisition spacing", gap, ACQ_CYC);
      if (ovl) begin
        chk(sync_busy == 1'b1, "R7 frame during conversion", int'(sync_busy), 1);
        chk(!busy, "R7 ready after busy low", int'(busy), 0);
      end else begin
        chk(sync_busy == 1'b0 && conv_starts == c0 + 1, "R6 frame after conversion", int'(sync_busy), 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int f0, v0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && sync_n && !sclk && !convst && !res_valid, "R1 reset outputs",
        {req_ready, sync_n, sclk, convst, res_valid}, 5'b11000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready && sync_n && !sclk && !convst && !res_valid, "R1 after reset",
        {req_ready, sync_n, sclk, convst, res_valid}, 5'b11000);

    for (int i = 0; i < 6; i++)
      run_req(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

    // R10: requests while busy are ignored
    wait_ready();
    adc_tx = 16'h3C3C; f0 = frames; v0 = valid_cnt;
    req_valid = 1'b1; req_ovl = 1'b1; req_sw = 1'b0; req_word = 16'h1234;
    @(negedge clk);
    req_word = 16'hBEEE;
    repeat (40) @(negedge clk);
    chk(!req_ready, "R10 ready low while running", int'(req_ready), 0);
    req_valid = 1'b0;
    wait_ready();
    repeat (600) @(negedge clk);
    chk(frames == f0 + 1, "R10 no extra frame", frames - f0, 1);
    chk(valid_cnt == v0 + 1, "R10 single result", valid_cnt - v0, 1);
    chk(m_last == 16'h1234, "R10 original word kept", int'(m_last), 16'h1234);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule